// File: doc/BRIEF.md
# Brightness Gamma Table Loader

This block serves brightness changes for a display panel. A request brings in a level from 0 to 10. The block picks the matching row of gamma parameters from a constant table and streams it out one byte per cycle to a command-writer port, as a single marked sequence. Right after that row it sends a short two-byte commit sequence, and the panel applies the new gamma only when that commit arrives. Serial framing toward the panel belongs to the writer and is not part of this block.

Each row is made of a command byte, a parameter selector, a three-byte preamble that is the same for every level, and eighteen bytes that depend on the level. Only those eighteen bytes are stored for each level. The command byte, the selector and the preamble are produced by logic.

The writer can flag a transfer error at any point during an update. The block keeps that flag until the update finishes, reports it together with the completion pulse, and then clears it. A request that comes in while an update is running is held, and it starts once the current update has finished.

Top module: `gamma_loader`

## Requirements
- R1: After reset, byte_vld_o, first_o, last_o, done_o and err_o are all low.
- R2: An accepted request produces a row of 23 bytes in this order: 0xFA, 0x00, 0x18, 0x08, 0x24, then 18 bytes that depend on the level. first_o is high only on the 0xFA byte and last_o only on byte 23. The row starts in the cycle after the request edge.
- R3: The commit sequence follows in the cycle after row byte 23. It is 0xFA with first_o high, then 0x01 with last_o high.
- R4: The level selects the row. Counting row bytes from 1, byte 6 and byte 23 are: level 0 gives 0x78 and 0x51, level 3 gives 0x6C and 0x9E, level 7 gives 0x62 and 0xDA, level 10 gives 0x5F and 0xDB.
- R5: A requested level above 10 sends the row of level 10.
- R6: done_o pulses high for exactly one cycle, in the cycle after the commit's last byte. byte_vld_o is low in that cycle.
- R7: If xfer_err_i is high in any cycle while byte_vld_o is high, err_o is high together with that update's done_o. err_o is never high without done_o. The flag is cleared afterwards, so the next update with no new error reports err_o low.
- R8: A request that arrives while an update is running is held. Its row starts in the cycle after the running update's done_o, with no request needed at that time.
- R9: The level is captured when the request is accepted. Changing level_i during an update has no effect on the bytes of that update.
- R10: byte_vld_o stays high without a gap for all 25 bytes of an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_i | input | 4 | Requested brightness level |
| req_i | input | 1 | Request strobe |
| xfer_err_i | input | 1 | Transfer error reported by the writer |
| byte_o | output | 8 | Stream byte |
| byte_vld_o | output | 1 | byte_o is valid |
| first_o | output | 1 | First byte of a sequence |
| last_o | output | 1 | Last byte of a sequence |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error status, valid together with done_o |

## Verification
The hardest case to reach from the ports is a request that lands in the middle of a running update. The held level then has to survive the update's end and start a new row on its own, while level_i has meanwhile been changed to an unrelated value. The stimulus raises a second request at a chosen byte index inside the stream and keeps scrambling level_i on every other byte. It then collects the next update without issuing any request and checks that update's level-specific bytes. Sticky error clearing is reached the same way: an error is injected mid-stream, and a clean update follows.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int LVL_W    = 4;
  localparam int NUM_LVL  = 11;
  localparam int MAX_LVL  = NUM_LVL - 1;
  localparam int ROW_LEN  = 23;
  localparam int HDR_LEN  = 5;
  localparam int VAR_LEN  = ROW_LEN - HDR_LEN;
  localparam int VAR_W    = 8 * VAR_LEN;
  localparam int CMT_LEN  = 2;
  localparam int IDX_W    = $clog2(ROW_LEN);

  localparam logic [7:0] CMD_GAMMA  = 8'hFA;
  localparam logic [7:0] SEL_LOAD   = 8'h00;
  localparam logic [7:0] SEL_COMMIT = 8'h01;

  typedef enum logic [1:0] {S_IDLE, S_ROW, S_CMT} seq_t;

  function automatic logic [LVL_W-1:0] clamp_lvl(input logic [LVL_W-1:0] l);
    return (int'(l) > MAX_LVL) ? LVL_W'(MAX_LVL) : l;
  endfunction

  function automatic logic [7:0] hdr_byte(input logic [IDX_W-1:0] i);
    case (i)
      IDX_W'(0): return CMD_GAMMA;
      IDX_W'(1): return SEL_LOAD;
      IDX_W'(2): return 8'h18;
      IDX_W'(3): return 8'h08;
      default:   return 8'h24;
    endcase
  endfunction

  function automatic logic [7:0] row_byte(input logic [VAR_W-1:0] v,
                                          input logic [IDX_W-1:0] i);
    int k;
    if (int'(i) < HDR_LEN) return hdr_byte(i);
    k = ROW_LEN - 1 - int'(i);
    return v[8*k +: 8];
  endfunction
endpackage

// File: rtl/gamma_rom.sv
module gamma_rom
  import gamma_pkg::*;
(
  input  logic [LVL_W-1:0] lvl,
  output logic [VAR_W-1:0] row
);
  always_comb begin
    case (lvl)
      4'd0:    row = 144'h78EC3DC8C2B6C4C7B6D5D7CC0039003600_51;
      4'd1:    row = 144'h734A3DC0C2B1BBBEACCECFC5005D005E00_82;
      4'd2:    row = 144'h70513EBFC1AFB9BCABCCCCC20065006700_8D;
      4'd3:    row = 144'h6C543ABCBFACB7BBA9C9C9BE0071007300_9E;
      4'd4:    row = 144'h695437BBBEACB4B7A6C7C8BC007B007E00_AB;
      4'd5:    row = 144'h665534BABDABB1B5A3C5C6B90085008800_BA;
      4'd6:    row = 144'h635331B8BCA9B0B5A2C4C4B8008B008E00_C2;
      4'd7:    row = 144'h625430B9BBA9B0B3A1C1C3B70091009500_DA;
      4'd8:    row = 144'h665834B6BAA7AFB3A0C1C2B70097009A00_D1;
      4'd9:    row = 144'h645633B6BAA8ACB19DC1C1B7009C009F00_D6;
      default: row = 144'h5F502DB6B9A7ADB19FBEC0B500A000A400_DB;
    endcase
  end
endmodule

// File: rtl/gamma_seq.sv
module gamma_seq
  import gamma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level_i,
  input  logic             req_i,
  output seq_t             state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             row_last_o,
  output logic             cmt_last_o,
  output logic             done_o
);
  seq_t             st_q;
  logic [IDX_W-1:0] idx_q;
  logic [LVL_W-1:0] lvl_q, pend_lvl_q;
  logic             pend_q, done_q;

  assign row_last_o = (st_q == S_ROW) && (int'(idx_q) == ROW_LEN - 1);
  assign cmt_last_o = (st_q == S_CMT) && (int'(idx_q) == CMT_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      idx_q      <= '0;
      lvl_q      <= LVL_W'(MAX_LVL);
      pend_lvl_q <= LVL_W'(MAX_LVL);
      pend_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= cmt_last_o;
      case (st_q)
        S_IDLE: begin
          if (req_i || pend_q) begin
            st_q   <= S_ROW;
            idx_q  <= '0;
            lvl_q  <= req_i ? clamp_lvl(level_i) : pend_lvl_q;
            pend_q <= 1'b0;
          end
        end
        S_ROW: begin
          if (row_last_o) begin
            st_q  <= S_CMT;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: begin
          if (cmt_last_o) begin
            st_q  <= S_IDLE;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      endcase
      if (st_q != S_IDLE && req_i) begin
        pend_q     <= 1'b1;
        pend_lvl_q <= clamp_lvl(level_i);
      end
    end
  end

  assign state_o = st_q;
  assign idx_o   = idx_q;
  assign lvl_o   = lvl_q;
  assign done_o  = done_q;
endmodule

// File: rtl/gamma_err.sv
module gamma_err (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic finish,
  input  logic err_in,
  output logic err_rpt
);
  logic flag_q, rpt_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      rpt_q  <= 1'b0;
    end else begin
      rpt_q  <= finish && (flag_q || err_in);
      flag_q <= finish ? 1'b0 : (flag_q || (busy && err_in));
    end
  end
  assign err_rpt = rpt_q;
endmodule

// File: rtl/gamma_loader.sv
module gamma_loader
  import gamma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level_i,
  input  logic             req_i,
  input  logic             xfer_err_i,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic             first_o,
  output logic             last_o,
  output logic             done_o,
  output logic             err_o
);
  seq_t             state_w;
  logic [IDX_W-1:0] idx_w;
  logic [LVL_W-1:0] lvl_w;
  logic [VAR_W-1:0] row_w;
  logic             row_last_w, cmt_last_w, busy_w;

  gamma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .level_i(level_i), .req_i(req_i),
    .state_o(state_w), .idx_o(idx_w), .lvl_o(lvl_w),
    .row_last_o(row_last_w), .cmt_last_o(cmt_last_w), .done_o(done_o)
  );

  gamma_rom u_rom (.lvl(lvl_w), .row(row_w));

  assign busy_w = (state_w != S_IDLE);

  gamma_err u_err (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .finish(cmt_last_w),
    .err_in(xfer_err_i), .err_rpt(err_o)
  );

  always_comb begin
    case (state_w)
      S_ROW:   byte_o = row_byte(row_w, idx_w);
      S_CMT:   byte_o = (idx_w == '0) ? CMD_GAMMA : SEL_COMMIT;
      default: byte_o = 8'h00;
    endcase
  end

  assign byte_vld_o = busy_w;
  assign first_o    = busy_w && (idx_w == '0);
  assign last_o     = row_last_w || cmt_last_w;
endmodule

// File: rtl/gamma_loader_chk.sv
module gamma_loader_chk
  import gamma_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       byte_o,
  input logic             byte_vld_o,
  input logic             first_o,
  input logic             done_o,
  input logic             err_o,
  input logic             row_last,
  input logic             cmt_last,
  input logic [LVL_W-1:0] lvl
);
  p_first_is_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    first_o |-> (byte_vld_o && byte_o == CMD_GAMMA));
  p_start_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_vld_o) |-> first_o);
  p_commit_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    row_last |=> (first_o && byte_o == CMD_GAMMA));
  p_commit_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_last |-> byte_o == SEL_COMMIT);
  p_lvl_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lvl) <= MAX_LVL);
  p_done_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_last |=> (done_o && !byte_vld_o));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);
endmodule

bind gamma_loader gamma_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_o(byte_o), .byte_vld_o(byte_vld_o),
  .first_o(first_o), .done_o(done_o), .err_o(err_o),
  .row_last(row_last_w), .cmt_last(cmt_last_w), .lvl(lvl_w)
);

// File: tb/sim_gamma_loader.sv
module sim_gamma_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] level_i = '0;
  logic       req_i = 1'b0;
  logic       xfer_err_i = 1'b0;
  logic [7:0] byte_o;
  logic       byte_vld_o, first_o, last_o, done_o, err_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] cap_b [32];
  logic       cap_f [32];
  logic       cap_l [32];
  int         cap_n;
  logic       cap_done, cap_err;

  // level, byte 6, byte 23
  localparam logic [19:0] VEC [6] = '{
    {4'd0,  8'h78, 8'h51}, {4'd3,  8'h6C, 8'h9E}, {4'd7,  8'h62, 8'hDA},
    {4'd10, 8'h5F, 8'hDB}, {4'd12, 8'h5F, 8'hDB}, {4'd15, 8'h5F, 8'hDB}};

  always #4 clk = ~clk;

  gamma_loader u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic capture(input bit do_req, input logic [3:0] lvl,
                         input int err_at, input int req2_at, input logic [3:0] lvl2);
    cap_n = 0;
    if (do_req) begin
      level_i = lvl; req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
    end
    while (byte_vld_o && cap_n < 32) begin
      cap_b[cap_n] = byte_o; cap_f[cap_n] = first_o; cap_l[cap_n] = last_o;
      xfer_err_i = (cap_n == err_at);
      req_i = (cap_n == req2_at);
      level_i = (cap_n == req2_at) ? lvl2 : 4'(cap_n);  // R9 scramble
      cap_n++;
      @(negedge clk);
    end
    xfer_err_i = 1'b0; req_i = 1'b0;
    cap_done = done_o; cap_err = err_o;
  endtask

  task automatic check_stream(input string tg, input logic [7:0] b6, input logic [7:0] b23);
    bit mk;
    chk(cap_n == 25, {tg, " R10 length"}, cap_n, 25);
    chk(cap_b[0] == 8'hFA && cap_b[1] == 8'h00 && cap_b[2] == 8'h18 &&
        cap_b[3] == 8'h08 && cap_b[4] == 8'h24, {tg, " R2 header"}, cap_b[1], 0);
    chk(cap_b[5] == b6, {tg, " R4 byte6"}, cap_b[5], b6);
    chk(cap_b[22] == b23, {tg, " R4 byte23"}, cap_b[22], b23);
    chk(cap_b[23] == 8'hFA && cap_b[24] == 8'h01, {tg, " R3 commit"}, cap_b[24], 1);
    mk = 1;
    for (int i = 0; i < 25; i++) begin
      if (cap_f[i] != (i == 0 || i == 23)) mk = 0;
      if (cap_l[i] != (i == 22 || i == 24)) mk = 0;
    end
    chk(mk, {tg, " R2 R3 markers"}, mk, 1);
    chk(cap_done && !byte_vld_o, {tg, " R6 done"}, cap_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!byte_vld_o && !first_o && !last_o && !done_o && !err_o, "R1 reset",
        {byte_vld_o, first_o, last_o, done_o, err_o}, 0);

    foreach (VEC[v]) begin
      capture(1'b1, VEC[v][19:16], -1, -1, 4'd0);
      check_stream($sformatf("vec%0d R4 R5", v), VEC[v][15:8], VEC[v][7:0]);
      chk(!cap_err, "R7 no error", cap_err, 0);
      @(negedge clk);
      chk(!done_o, "R6 single pulse", done_o, 0);
    end

    capture(1'b1, 4'd3, 10, -1, 4'd0);
    check_stream("err", 8'h6C, 8'h9E);
    chk(cap_err, "R7 error reported", cap_err, 1);
    @(negedge clk);
    chk(!err_o, "R7 err only with done", err_o, 0);
    capture(1'b1, 4'd0, -1, -1, 4'd0);
    chk(cap_done && !cap_err, "R7 cleared", cap_err, 0);
    @(negedge clk);

    capture(1'b1, 4'd10, -1, 6, 4'd7);
    check_stream("held first R9", 8'h5F, 8'hDB);
    @(negedge clk);
    chk(byte_vld_o && first_o && byte_o == 8'hFA, "R8 held start", byte_o, 8'hFA);
    capture(1'b0, 4'd0, -1, -1, 4'd0);
    check_stream("held second R8", 8'h62, 8'hDA);

    @(negedge clk);
    chk(!byte_vld_o, "R8 no spurious start", byte_vld_o, 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule